// File: doc/BRIEF.md
# Flash Read Address Sequencer with Burst Wrap

This block produces the byte address stream for a serial flash read. A load strobe captures a start address and a burst setting. Each byte-advance strobe then moves the current address forward by one byte. The array is 32 MB, so the current address is 25 bits wide.

In narrow (3-byte) address mode, the low 24 bits come from the loaded address and the top bit comes from a one-bit extended-segment input. That input picks the lower or upper 16 MB half. In wide (4-byte) address mode, the loaded address supplies every bit, and the segment input has no effect.

Reads run in one of two ways. A continuous read covers the whole array and rolls over at the end. A wrapped read stays inside an aligned 16-, 32- or 64-byte burst, so a cache-line fill can start at the critical byte.

The strobes are plain single-cycle controls with no handshake. The sequencer takes a strobe in every cycle in which it is high and never stalls the source, so no back-pressure exists on either strobe. The wrap setting and the segment bit are captured only on a load.

Top module: `fladdr_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `addr_o` is 0 and the burst mode is continuous.
- R2: A load with `wide_addr_i`=0 sets `addr_o` on the next clock edge to {`ext_seg_i`, `load_addr_i[23:0]`}.
- R3: A load with `wide_addr_i`=1 sets `addr_o` to `load_addr_i[24:0]`. `ext_seg_i` and `load_addr_i[31:25]` have no effect.
- R4: In continuous mode (`wrap_sel_i`=2'b00 at load), each advance makes `addr_o` one greater on the next edge.
- R5: In continuous mode, an advance from 25'h1FFFFFF gives 0.
- R6: The wrap codes are 2'b01 for a 16-byte burst, 2'b10 for 32 bytes and 2'b11 for 64 bytes. In a wrapped burst, an advance increments only the low 4, 5 or 6 bits, and every higher bit stays as it was.
- R7: In wrapped mode the address wraps back to the start of its aligned burst. A 16-byte burst from 15 runs 15, 0, 1. A 16-byte burst from 31 runs 31, 16. A 32-byte burst from 15 runs 15, 16.
- R8: When a load and an advance are high in the same cycle, the load wins and `addr_o` becomes the start address.
- R9: With both strobes low, `addr_o` holds its value.
- R10: A change on `wrap_sel_i` or `ext_seg_i` has no effect until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe; captures the start address, the wrap setting and the segment bit |
| load_addr_i | input | 32 | Start address |
| wide_addr_i | input | 1 | 1 selects 4-byte addressing, 0 selects 3-byte addressing |
| wrap_sel_i | input | 2 | Burst setting: 00 continuous, 01 16 bytes, 10 32 bytes, 11 64 bytes |
| ext_seg_i | input | 1 | Extended-segment bit; used only in 3-byte mode |
| advance_i | input | 1 | Byte-advance strobe |
| addr_o | output | 25 | Current byte address |

## Verification
Start addresses are loaded in both address modes, with the segment bit and the unused upper address bits set against the expected result. This shows whether the source of bit 24 is chosen correctly.

Advances are applied at the end of the array and at the end of each burst size. The start points are chosen so that bursts begin mid-way and at an unaligned address, which tells a true aligned wrap apart from a plain increment or a mask of the wrong size.

Two further cases are driven:
- A load and an advance in the same cycle, which shows the load taking priority.
- Changes to the wrap and segment inputs while no load is pending, which show whether those settings are captured at load or read live.

Long runs of advances in continuous and 64-byte modes are compared against an address computed in the bench.

// File: rtl/fas_pkg.sv
package fas_pkg;
  localparam int FAS_ARRAY_AW   = 25;
  localparam int FAS_LOAD_W     = 32;
  localparam int FAS_NARROW_W   = 24;
  localparam int FAS_WRAP_SIZES = 3;
  localparam int FAS_WRAP_MINLG = 4;

  typedef enum logic [1:0] {
    BURST_LINEAR = 2'b00,
    BURST_16     = 2'b01,
    BURST_32     = 2'b10,
    BURST_64     = 2'b11
  } burst_e;
endpackage

// File: rtl/fas_start_addr.sv
module fas_start_addr #(
  parameter int AW      = fas_pkg::FAS_ARRAY_AW,
  parameter int LOAD_W  = fas_pkg::FAS_LOAD_W,
  parameter int SEG_LSB = fas_pkg::FAS_NARROW_W,
  localparam int EXT_W  = AW - SEG_LSB
) (
  input  logic [LOAD_W-1:0] load_addr,
  input  logic              wide_mode,
  input  logic [EXT_W-1:0]  ext_seg,
  output logic [AW-1:0]     start_addr
);
  logic [AW-1:0] narrow_form;
  logic [AW-1:0] wide_form;

  // narrow mode: segment register supplies the bits above the 3-byte field
  assign narrow_form = {ext_seg, load_addr[SEG_LSB-1:0]};
  // wide mode: the loaded address supplies all bits the array decodes
  assign wide_form   = load_addr[AW-1:0];

  assign start_addr  = wide_mode ? wide_form : narrow_form;
endmodule

// File: rtl/fas_wrap_step.sv
module fas_wrap_step #(
  parameter int AW         = fas_pkg::FAS_ARRAY_AW,
  parameter int WRAP_SIZES = fas_pkg::FAS_WRAP_SIZES,
  parameter int MIN_LG     = fas_pkg::FAS_WRAP_MINLG,
  localparam int MW        = $clog2(WRAP_SIZES + 1)
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [MW-1:0] burst_mode,
  output logic [AW-1:0] next_addr
);
  logic [AW-1:0] bumped;
  logic [AW-1:0] cand [WRAP_SIZES+1];

  assign bumped  = cur_addr + 1'b1;
  assign cand[0] = bumped;

  for (genvar g = 0; g < WRAP_SIZES; g++) begin : g_burst
    localparam int LG = MIN_LG + g;
    localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << LG) - 64'd1);
    // upper bits frozen, low bits count modulo the burst length
    assign cand[g+1] = (cur_addr & ~LOW_MASK) | (bumped & LOW_MASK);
  end

  always_comb begin
    next_addr = cand[0];
    for (int i = 1; i <= WRAP_SIZES; i++) begin
      if (burst_mode == MW'(i)) next_addr = cand[i];
    end
  end
endmodule

// File: rtl/fas_addr_reg.sv
module fas_addr_reg #(
  parameter int AW = fas_pkg::FAS_ARRAY_AW,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] start_addr,
  input  logic [MW-1:0] burst_sel,
  input  logic          advance,
  input  logic [AW-1:0] next_addr,
  output logic [AW-1:0] cur_addr,
  output logic [MW-1:0] cur_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_addr <= '0;
      cur_mode <= '0;
    end else if (load) begin
      // load outranks a coincident advance
      cur_addr <= start_addr;
      cur_mode <= burst_sel;
    end else if (advance) begin
      cur_addr <= next_addr;
    end
  end
endmodule

// File: rtl/fladdr_seq.sv
module fladdr_seq #(
  parameter int AW         = fas_pkg::FAS_ARRAY_AW,
  parameter int LOAD_W     = fas_pkg::FAS_LOAD_W,
  parameter int SEG_LSB    = fas_pkg::FAS_NARROW_W,
  parameter int WRAP_SIZES = fas_pkg::FAS_WRAP_SIZES,
  parameter int MIN_LG     = fas_pkg::FAS_WRAP_MINLG,
  localparam int EXT_W     = AW - SEG_LSB,
  localparam int MW        = $clog2(WRAP_SIZES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [LOAD_W-1:0] load_addr_i,
  input  logic              wide_addr_i,
  input  logic [MW-1:0]     wrap_sel_i,
  input  logic [EXT_W-1:0]  ext_seg_i,
  input  logic              advance_i,
  output logic [AW-1:0]     addr_o
);
  logic [AW-1:0] start_addr;
  logic [AW-1:0] next_addr;
  logic [AW-1:0] cur_addr;
  logic [MW-1:0] cur_mode;

  fas_start_addr #(.AW(AW), .LOAD_W(LOAD_W), .SEG_LSB(SEG_LSB)) u_start (
    .load_addr (load_addr_i),
    .wide_mode (wide_addr_i),
    .ext_seg   (ext_seg_i),
    .start_addr(start_addr)
  );

  fas_wrap_step #(.AW(AW), .WRAP_SIZES(WRAP_SIZES), .MIN_LG(MIN_LG)) u_step (
    .cur_addr  (cur_addr),
    .burst_mode(cur_mode),
    .next_addr (next_addr)
  );

  fas_addr_reg #(.AW(AW), .MW(MW)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_i),
    .start_addr(start_addr),
    .burst_sel (wrap_sel_i),
    .advance   (advance_i),
    .next_addr (next_addr),
    .cur_addr  (cur_addr),
    .cur_mode  (cur_mode)
  );

  assign addr_o = cur_addr;
endmodule

// File: rtl/fas_seq_chk.sv
module fas_seq_chk #(
  parameter int AW      = 25,
  parameter int LOAD_W  = 32,
  parameter int SEG_LSB = 24,
  parameter int EXT_W   = 1,
  parameter int MW      = 2,
  parameter int MAX_LG  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic [LOAD_W-1:0] load_addr_i,
  input logic              wide_addr_i,
  input logic [MW-1:0]     wrap_sel_i,
  input logic [EXT_W-1:0]  ext_seg_i,
  input logic              advance_i,
  input logic [AW-1:0]     addr_o
);
  logic [MW-1:0] seen_mode;

  always_ff @(posedge clk) begin
    if (!rst_n)      seen_mode <= '0;
    else if (load_i) seen_mode <= wrap_sel_i;
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !advance_i) |=> $stable(addr_o)); // R9

  AST_NARROW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !wide_addr_i) |=>
      addr_o == {$past(ext_seg_i), $past(load_addr_i[SEG_LSB-1:0])}); // R2

  AST_WIDE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && wide_addr_i) |=> addr_o == $past(load_addr_i[AW-1:0])); // R3

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && seen_mode == '0) |=>
      addr_o == $past(addr_o) + 1'b1); // R4

  AST_BURST_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && !load_i && seen_mode != '0) |=>
      addr_o[AW-1:MAX_LG] == $past(addr_o[AW-1:MAX_LG])); // R6
endmodule

bind fladdr_seq fas_seq_chk #(
  .AW(AW), .LOAD_W(LOAD_W), .SEG_LSB(SEG_LSB), .EXT_W(EXT_W), .MW(MW),
  .MAX_LG(MIN_LG + WRAP_SIZES - 1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
  .wide_addr_i(wide_addr_i), .wrap_sel_i(wrap_sel_i), .ext_seg_i(ext_seg_i),
  .advance_i(advance_i), .addr_o(addr_o)
);

// File: tb/fladdr_seq_test.sv
module fladdr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [31:0] load_addr_i = '0;
  logic        wide_addr_i = 1'b0;
  logic [1:0]  wrap_sel_i = 2'b00;
  logic [0:0]  ext_seg_i = 1'b0;
  logic        advance_i = 1'b0;
  logic [24:0] addr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  fladdr_seq uut (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_addr_i(load_addr_i),
    .wide_addr_i(wide_addr_i), .wrap_sel_i(wrap_sel_i), .ext_seg_i(ext_seg_i),
    .advance_i(advance_i), .addr_o(addr_o)
  );

  typedef struct packed {
    logic        ld;
    logic [31:0] a;
    logic        wide;
    logic [1:0]  ws;
    logic        seg;
    logic        adv;
    logic [24:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h00ABCDEF, 1'b0, 2'b00, 1'b1, 1'b0, 25'h1ABCDEF, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h1ABCDF0, 4'd4},  // R4
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h1ABCDF1, 4'd4},  // R4
    '{1'b1, 32'hFE001234, 1'b1, 2'b00, 1'b1, 1'b0, 25'h0001234, 4'd3},  // R3
    '{1'b1, 32'h01FFFFFE, 1'b1, 2'b00, 1'b0, 1'b0, 25'h1FFFFFE, 4'd3},  // R3
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h1FFFFFF, 4'd4},  // R4
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000000, 4'd5},  // R5
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b0, 25'h0000000, 4'd9},  // R9
    '{1'b1, 32'h0000000F, 1'b0, 2'b01, 1'b0, 1'b0, 25'h000000F, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000000, 4'd7},  // R7
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000001, 4'd7},  // R7
    '{1'b1, 32'h0000001F, 1'b0, 2'b01, 1'b0, 1'b0, 25'h000001F, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000010, 4'd7},  // R7
    '{1'b1, 32'h0000000F, 1'b0, 2'b10, 1'b0, 1'b0, 25'h000000F, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000010, 4'd7},  // R7
    '{1'b1, 32'h0000003F, 1'b0, 2'b10, 1'b0, 1'b0, 25'h000003F, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h0000020, 4'd6},  // R6
    '{1'b1, 32'h00FFFFFF, 1'b0, 2'b11, 1'b1, 1'b0, 25'h1FFFFFF, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b1, 25'h1FFFFC0, 4'd6},  // R6
    '{1'b0, 32'h0,        1'b0, 2'b00, 1'b0, 1'b0, 25'h1FFFFC0, 4'd9},  // R9
    '{1'b1, 32'h00000100, 1'b0, 2'b00, 1'b0, 1'b1, 25'h0000100, 4'd8},  // R8
    '{1'b1, 32'h0000010F, 1'b0, 2'b00, 1'b0, 1'b0, 25'h000010F, 4'd2},  // R2
    '{1'b0, 32'h0,        1'b0, 2'b01, 1'b1, 1'b1, 25'h0000110, 4'd10}, // R10
    '{1'b0, 32'h0,        1'b0, 2'b11, 1'b1, 1'b0, 25'h0000110, 4'd10}  // R10
  };

  task automatic check(input logic [24:0] exp, input int rq, input string what);
    checks++;
    if (addr_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, addr_o, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic ld, input logic [31:0] a, input logic wide,
                     input logic [1:0] ws, input logic seg, input logic adv);
    load_i = ld; load_addr_i = a; wide_addr_i = wide;
    wrap_sel_i = ws; ext_seg_i = seg; advance_i = adv;
    @(negedge clk);
    load_i = 1'b0; advance_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [24:0] exp;
    repeat (3) @(negedge clk);
    check(25'h0, 1, "address during reset");                       // R1
    rst_n = 1'b1;
    @(negedge clk);
    check(25'h0, 1, "address after reset release");                // R1

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i].ld, VEC[i].a, VEC[i].wide, VEC[i].ws, VEC[i].seg, VEC[i].adv);
      check(VEC[i].exp, int'(VEC[i].rq), $sformatf("vector %0d", i));
    end

    // R4 R5: long linear run across the top of the array
    cyc(1'b1, 32'h01FFFFF0, 1'b1, 2'b00, 1'b0, 1'b0);
    exp = 25'h1FFFFF0;
    for (int k = 0; k < 40; k++) begin
      cyc(1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1);
      exp = exp + 25'd1;
      check(exp, 5, "linear run over array end");
    end

    // R6: 64-byte burst from an unaligned start, many turns
    cyc(1'b1, 32'h00123465, 1'b0, 2'b11, 1'b1, 1'b0);
    for (int k = 1; k <= 130; k++) begin
      cyc(1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1);
      exp = {1'b1, 24'h123440} | 25'((6'h25 + k) % 64);
      check(exp, 6, "64-byte burst run");
    end

    // R1: reset mid-burst returns to 0 and to linear stepping
    rst_n = 1'b0;
    @(negedge clk);
    check(25'h0, 1, "reset mid-burst");
    rst_n = 1'b1;
    @(negedge clk);
    cyc(1'b1, 32'h0000003F, 1'b0, 2'b11, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(25'h0, 1, "reset clears loaded address");
    for (int k = 1; k <= 70; k++) begin
      cyc(1'b0, 32'h0, 1'b0, 2'b00, 1'b0, 1'b1);
      check(25'(k), 1, "linear mode after reset");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule